// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an asynchronous static RAM of 256K words by 16 bits. The host issues one request at a time on a valid/ready port. Each request is a read or a write of one word, and a two-bit lane mask picks which bytes take part. The controller turns every request into a strobe sequence on the RAM. Chip select, output enable, write enable and the two byte selects are all active low and all come from registers, so they never glitch.

Every timing window is a parameter counted in clock cycles:

- read access time,
- write pulse width,
- time the RAM outputs need to reach high-Z after a read.

The address changes only while write enable is high. The write data is driven for a full cycle before write enable falls. The controller drives the bus only after the RAM has released it.

Read data returns on a one-cycle response strobe. Any lane that was not selected reads back as zero.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, the chip select, output enable, write enable and both byte selects are all high. The data drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: Lane mask bit 0 selects the lower lane (data bits 7:0) and drives `mem_lb_n` low. Mask bit 1 selects the upper lane (bits 15:8) and drives `mem_ub_n` low. Only the selected lanes change in the RAM on a write.
- R3: A read holds chip select and output enable low and write enable high for `T_RD` cycles. The data is captured on the edge that ends that window. `rsp_valid` is high for exactly one cycle, `T_RD` cycles after the edge that accepted the request.
- R4: In the read response, any lane whose mask bit is 0 reads as zero. A read with mask 2'b00 returns 16'h0000.
- R5: A write with a non-zero mask has three parts, all with chip select low and output enable high:
  - one setup cycle with write enable high and data driven;
  - `T_WP` cycles with write enable low;
  - one recovery cycle with write enable high and data still driven.
- R6: `mem_addr` changes only when write enable is high both before and after the change.
- R7: The write data is driven for at least one cycle before write enable falls, and it stays unchanged while write enable is low.
- R8: After output enable rises at the end of a read, the data drive enable stays low for at least `T_HZ` further cycles.
- R9: A write with mask 2'b00 is accepted without any strobe activity. Chip select stays high, `req_ready` is high again on the next cycle, and the RAM contents are unchanged.
- R10: `req_ready` is high only while the controller is idle, so after a read is accepted it is low on the next cycle.
- R11: The controller never drives the data bus while output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 18 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_lb_n | output | 1 | RAM lower byte select, active low |
| mem_ub_n | output | 1 | RAM upper byte select, active low |
| mem_dq_out | output | 16 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data sampled from the RAM |

## Verification
The properties assume the following about the host: `req_valid` and the request fields stay steady until the handshake completes, and the RAM returns stable data by the end of the programmed access window. The bench meets both by holding every field from the falling edge at which it raises `req_valid` until the cycle after acceptance. Its behavioural RAM answers reads combinationally and commits a write when write enable rises. Unselected lanes of the RAM model return the filler bytes 8'hEE and 8'hDD, so any lane that the controller fails to mask shows up in the read data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_WR_SET   = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_WR_REC   = 3'd4,
    ST_TURN     = 3'd5
  } ctrl_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_decode.sv
module sram_lane_decode #(
  parameter int LANES = 2
) (
  input  logic             active,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] sel_n
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sel_n[g] = ~(active & mask[g]);
  end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [LANES-1:0]  mask,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] rdata_d;
  logic              rvalid_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign masked[g*8 +: 8] = mask[g] ? dq_in[g*8 +: 8] : 8'h00;
  end

  always_comb begin
    rvalid_d = cap_en;
    rdata_d  = rdata;
    if (cap_en) rdata_d = masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rvalid_d;
      rdata  <= rdata_d;
    end
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int T_RD   = 1,
  parameter int T_WP   = 1,
  parameter int T_HZ   = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W/8-1:0]    req_mask,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_cs_n,
  output logic                   mem_oe_n,
  output logic                   mem_we_n,
  output logic                   mem_lb_n,
  output logic                   mem_ub_n,
  output logic [DATA_W-1:0]      mem_dq_out,
  output logic                   mem_dq_oe,
  input  logic [DATA_W-1:0]      mem_dq_in
);
  localparam int LANES = DATA_W / 8;
  localparam int TMAX  = max3(T_RD, T_WP, T_HZ);
  localparam int CNT_W = (TMAX < 2) ? 1 : $clog2(TMAX);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  ctrl_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q, mask_sel;
  logic              accept, tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic              lane_act_d;
  logic [LANES-1:0]  sel_n_d;
  logic              cs_n_d, oe_n_d, we_n_d, dq_oe_d;
  logic              cap_en;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign mask_sel  = accept ? req_mask : mask_q;

  // next-state
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (!req_write) begin
            state_d  = ST_RD_ACC;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_RD - 1);
          end else if (req_mask != '0) begin
            state_d = ST_WR_SET;
          end
        end
      end
      ST_RD_ACC: begin
        if (tmr_done) begin
          state_d  = ST_TURN;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_HZ - 1);
        end
      end
      ST_WR_SET: begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_WP - 1);
      end
      ST_WR_PULSE: if (tmr_done) state_d = ST_WR_REC;
      ST_WR_REC:   state_d = ST_IDLE;
      ST_TURN:     if (tmr_done) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // strobe values for the coming cycle
  always_comb begin
    cs_n_d     = (state_d == ST_IDLE) || (state_d == ST_TURN);
    oe_n_d     = (state_d != ST_RD_ACC);
    we_n_d     = (state_d != ST_WR_PULSE);
    dq_oe_d    = (state_d == ST_WR_SET) || (state_d == ST_WR_PULSE) ||
                 (state_d == ST_WR_REC);
    lane_act_d = !cs_n_d;
  end

  sram_lane_decode #(.LANES(LANES)) u_lane (
    .active (lane_act_d),
    .mask   (mask_sel),
    .sel_n  (sel_n_d)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  assign cap_en = (state_q == ST_RD_ACC) && tmr_done;

  sram_rd_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_cap (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cap_en (cap_en),
    .mask   (mask_q),
    .dq_in  (mem_dq_in),
    .rvalid (rsp_valid),
    .rdata  (rsp_rdata)
  );

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      wdata_q    <= '0;
      mask_q     <= '0;
      mem_cs_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
    end else begin
      state_q   <= state_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        mask_q  <= req_mask;
      end
      mem_cs_n  <= cs_n_d;
      mem_oe_n  <= oe_n_d;
      mem_we_n  <= we_n_d;
      mem_lb_n  <= sel_n_d[0];
      mem_ub_n  <= sel_n_d[LANES-1];
      mem_dq_oe <= dq_oe_d;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [DATA_W/8-1:0] req_mask,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  // R6
  addr_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != $past(mem_addr)) |-> (mem_we_n && $past(mem_we_n)));

  // R5
  we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));

  // R7
  wdata_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($stable(mem_dq_out) && $past(mem_dq_oe)));

  // R11
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  // R3
  rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

  // R9
  empty_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_mask == '0) |=> (mem_cs_n && req_ready));

  // R8
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !mem_dq_oe);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_mask(req_mask), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
  localparam int T_RD = 3;
  localparam int T_WP = 2;
  localparam int T_HZ = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [17:0] mem_addr;

  always #5 clk = ~clk;

  sram_lane_ctrl #(.T_RD(T_RD), .T_WP(T_WP), .T_HZ(T_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit done_flag = 0, mon_on = 0;
  logic [15:0] sram   [0:1023];
  logic [15:0] shadow [0:1023];
  logic [15:0] exp_q[$];
  logic [1:0]  msk_q[$];
  int          acc_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // RAM model: reads combinational, writes commit when WE rises
  always_comb begin
    mem_dq_in[7:0]  = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_lb_n) ? sram[mem_addr[9:0]][7:0]  : 8'hEE;
    mem_dq_in[15:8] = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_ub_n) ? sram[mem_addr[9:0]][15:8] : 8'hDD;
  end

  initial begin
    logic        wpend;
    logic [9:0]  widx;
    logic [15:0] wdat;
    logic [1:0]  wln;
    for (int i = 0; i < 1024; i++) sram[i] = 16'h0;
    wpend = 0; widx = '0; wdat = '0; wln = '0;
    forever begin
      @(negedge clk);
      if (!mem_we_n && !mem_cs_n) begin
        wpend = 1; widx = mem_addr[9:0]; wdat = mem_dq_out;
        wln = {~mem_ub_n, ~mem_lb_n};
      end else if (wpend && mem_we_n) begin
        if (wln[0]) sram[widx][7:0]  = wdat[7:0];
        if (wln[1]) sram[widx][15:8] = wdat[15:8];
        wpend = 0;
      end
    end
  end

  // port monitor and scoreboard
  initial begin
    logic [17:0] p_addr;
    logic p_we, p_oe_dq;
    logic [15:0] fall_dat;
    int gap, wlow;
    bit stable;
    p_addr = '0; p_we = 1; p_oe_dq = 0; fall_dat = '0; gap = 100; wlow = 0; stable = 1;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (mem_addr != p_addr)
          check(mem_we_n && p_we, "R6 addr change with WE low", {mem_we_n, p_we}, 2'b11);
        if (mem_dq_oe && !p_oe_dq) begin
          check(gap > T_HZ, "R8 drive after read gap", gap, T_HZ + 1);
          check(mem_oe_n, "R11 drive with OE low", mem_oe_n, 1);
        end
        if (p_we && !mem_we_n) begin
          check(p_oe_dq, "R7 data driven before WE fall", p_oe_dq, 1);
          fall_dat = mem_dq_out; wlow = 0; stable = 1;
        end
        if (!mem_we_n) begin
          wlow++;
          if (mem_dq_out != fall_dat) stable = 0;
        end
        if (!p_we && mem_we_n) begin
          check(wlow == T_WP, "R5 write pulse width", wlow, T_WP);
          check(stable && mem_dq_oe && !mem_cs_n, "R7 data held through pulse", {stable, mem_dq_oe, mem_cs_n}, 3'b110);
        end
        if (rsp_valid) begin
          if (exp_q.size() == 0) check(0, "R3 unexpected response", rsp_rdata, 0);
          else begin
            logic [15:0] e; logic [1:0] m; int a;
            e = exp_q.pop_front(); m = msk_q.pop_front(); a = acc_q.pop_front();
            check(rsp_rdata == e, (m == 2'b11) ? "R3 read data" : "R4 masked read data", rsp_rdata, e);
            check(cyc - a == T_RD, "R3 read latency", cyc - a, T_RD);
          end
        end
      end
      gap = !mem_oe_n ? 0 : gap + 1;
      p_addr = mem_addr; p_we = mem_we_n; p_oe_dq = mem_dq_oe;
    end
  end

  task automatic send(input logic w, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    req_write = w; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!w) begin
      exp_q.push_back(shadow[a[9:0]] & {{8{m[1]}}, {8{m[0]}}});
      msk_q.push_back(m);
      acc_q.push_back(cyc);
      check(!req_ready, "R10 ready low after read accept", req_ready, 0);
    end else begin
      if (m[0]) shadow[a[9:0]][7:0]  = d[7:0];
      if (m[1]) shadow[a[9:0]][15:8] = d[15:8];
      if (m == 2'b00)
        check(req_ready && mem_cs_n, "R9 empty write no cycle", {req_ready, mem_cs_n}, 2'b11);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) shadow[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n} == 5'b11111, "R1 strobes high",
          {mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'b11111);
    check(!mem_dq_oe, "R1 bus released", mem_dq_oe, 0);
    check(req_ready, "R1 ready", req_ready, 1);
    check(!rsp_valid, "R1 no response", rsp_valid, 0);
    mon_on = 1;

    send(1, 18'h00010, 16'hA5C3, 2'b11);
    send(0, 18'h00010, 16'h0, 2'b11);
    send(1, 18'h00010, 16'h1177, 2'b01);   // R2 lower lane only
    send(0, 18'h00010, 16'h0, 2'b11);
    send(1, 18'h00010, 16'h8899, 2'b10);   // R2 upper lane only
    send(1, 18'h00010, 16'hFFFF, 2'b00);   // R9
    send(0, 18'h00010, 16'h0, 2'b11);
    send(0, 18'h00010, 16'h0, 2'b01);      // R4
    send(0, 18'h00010, 16'h0, 2'b10);      // R4
    send(0, 18'h00010, 16'h0, 2'b00);      // R4
    send(1, 18'h3FFFF, 16'h5A5A, 2'b11);
    send(1, 18'h00000, 16'h0F0F, 2'b11);
    send(0, 18'h3FFFF, 16'h0, 2'b11);
    send(0, 18'h00000, 16'h0, 2'b11);
    for (int k = 0; k < 24; k++) begin
      logic [17:0] a;
      a = 18'(k * 37 + 100);
      send(1, a, 16'(k * 16'h1357 + 16'h2468), 2'((k % 3) + 1));
      send(0, a, 16'h0, 2'(k % 4));
      if (k % 5 == 0) send(0, 18'(a + 1), 16'h0, 2'b11);
    end
    repeat (T_RD + T_HZ + 4) @(negedge clk);
    check(exp_q.size() == 0, "R3 all responses seen", exp_q.size(), 0);
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule